// File: doc/BRIEF.md
# PS/2 Device-Side Host Command Receiver

This block sits in a PS/2 peripheral that generates the bus clock itself. When the host wants to send a command or argument byte, it first holds the clock line low, then pulls the data line low and lets the clock go. While the shared transmitter reports that it is idle, the receiver periodically looks for that request condition. When it finds it, the receiver drives the clock low once per bit cell and reads the data line during each released-high half of the cell. It collects eight data bits, least significant first, then a parity bit and a stop bit. A good frame is closed with an eleventh clock, during which the receiver also holds data low as the acknowledge.

The received byte comes out with a one-cycle valid strobe and a parity-error flag. If the stop bit reads low, the receiver keeps clocking until the host releases data and then pulses a request for the transmitter to send a Resend reply. If the host holds the clock low for the abort interval during a released phase, the receiver drops the partial byte, frees the bus and pulses an abort indication. Both bus lines are open-drain. The block reads their levels and only asserts "drive low" enables.

Top module: `ps2_host_cmd_rx`

## Requirements
- R1: After reset, both drive-low enables, `busy` and all three strobes are 0. The drive-low enables are 0 whenever `busy` is 0.
- R2: A frame starts only on a poll tick, which comes once every POLL_CYC cycles. At that tick `tx_idle` must be 1, the synchronized clock line must be high and the synchronized data line must be low. While `tx_idle` is 0, no clock is driven.
- R3: Every clock pulse the block drives holds `clk_drive_low` high for exactly HALF_CYC cycles. It is followed by a released phase of at least HALF_CYC cycles.
- R4: Clock pulse k (k = 1..8) carries data bit k-1, least significant bit first. Pulse 9 carries the parity bit and pulse 10 the stop bit. On a good frame `cmd_byte` shows the byte together with a one-cycle `cmd_valid`.
- R5: `cmd_par_err` is 1 exactly when the eight data bits plus the parity bit hold an even number of ones.
- R6: When the stop bit reads 1, `dat_drive_low` rises LEAD_CYC cycles before an eleventh clock pulse and stays high through that pulse's released phase. It falls in the same cycle that `cmd_valid` is strobed. A good frame has exactly 11 clock pulses.
- R7: When the stop bit reads 0, the block keeps issuing pulses until data reads high during a released phase. It then strobes `resend_req` once, strobes no `cmd_valid` and never drives data.
- R8: If the clock line reads low for ABORT_CYC consecutive cycles during a released phase, the block returns to idle with both lines released. It strobes `host_abort` and no `cmd_valid` for that frame.
- R9: A host hold on the clock shorter than ABORT_CYC during a released phase only stretches that cell. The frame still completes with the correct byte and no abort.
- R10: `cmd_valid`, `host_abort` and `resend_req` are one-cycle pulses, and no two are high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_i | input | 1 | Level read from the open-drain PS/2 clock line |
| bus_dat_i | input | 1 | Level read from the open-drain PS/2 data line |
| tx_idle | input | 1 | Transmitter is idle; the receiver may poll for a request |
| clk_drive_low | output | 1 | Pull the clock line low |
| dat_drive_low | output | 1 | Pull the data line low (acknowledge bit) |
| busy | output | 1 | A reception is in progress |
| cmd_valid | output | 1 | One-cycle strobe: `cmd_byte` holds a new byte |
| cmd_byte | output | DATA_W | Received byte |
| cmd_par_err | output | 1 | Parity check failed for `cmd_byte` |
| host_abort | output | 1 | One-cycle strobe: host aborted the frame |
| resend_req | output | 1 | One-cycle strobe: framing error, ask for a Resend reply |

## Verification
The embedded assertions run on every cycle. They check that each driven clock pulse lasts exactly HALF_CYC cycles, that the lines are released whenever the block is idle or has just aborted, that a frame only begins after a cycle with `tx_idle` high, that the acknowledge data-low leads the final falling edge and ends with the valid strobe, and that the strobes stay one cycle wide and never overlap. Some properties need a scripted host, so only the bench scenarios can show them. These are the decoded byte and parity flag against the sent bits, the number of pulses in good and framing-error frames, the exact acknowledge lead time, the abort, the harmless short stretch, and the refusal to start while the transmitter owns the bus.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_ACK_LEAD,
    ST_ACK_LOW,
    ST_ACK_HIGH
  } ps2rx_state_e;
endpackage

// File: rtl/ps2rx_sync.sv
module ps2rx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '1;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '1;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ps2rx_shift.sv
module ps2rx_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          bit_i,
  output logic [DW-1:0] data_o,
  output logic          odd_o
);
  logic [DW:0] sr;

  always_ff @(posedge clk) begin
    if (rst || clr) sr <= '0;
    else if (en)    sr <= {bit_i, sr[DW:1]};
  end

  assign data_o = sr[DW-1:0];
  assign odd_o  = ^sr;
endmodule

// File: rtl/ps2_host_cmd_rx.sv
module ps2_host_cmd_rx
  import ps2rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HALF_CYC    = 40,
  parameter int POLL_CYC    = 2000,
  parameter int ABORT_CYC   = 100,
  parameter int LEAD_CYC    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_clk_i,
  input  logic              bus_dat_i,
  input  logic              tx_idle,
  output logic              clk_drive_low,
  output logic              dat_drive_low,
  output logic              busy,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_byte,
  output logic              cmd_par_err,
  output logic              host_abort,
  output logic              resend_req
);
  localparam int CELL_W = $clog2(HALF_CYC + LEAD_CYC + 1);
  localparam int POLL_W = $clog2(POLL_CYC + 1);
  localparam int ABT_W  = $clog2(ABORT_CYC + 1);
  localparam int IDX_W  = $clog2(DATA_W + 3);
  localparam logic [CELL_W-1:0] HALF_END = CELL_W'(HALF_CYC - 1);
  localparam logic [CELL_W-1:0] LEAD_END = CELL_W'(LEAD_CYC - 1);
  localparam logic [CELL_W-1:0] SAMPLE_AT = CELL_W'(HALF_CYC / 2);
  localparam logic [CELL_W-1:0] GUARD = CELL_W'(SYNC_STAGES + 1);
  localparam logic [POLL_W-1:0] POLL_END = POLL_W'(POLL_CYC - 1);
  localparam logic [ABT_W-1:0] ABT_END = ABT_W'(ABORT_CYC - 1);
  localparam logic [IDX_W-1:0] PAR_IDX = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(DATA_W + 1);

  logic [1:0] line_s;
  logic       clk_s, dat_s;

  ps2rx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({bus_clk_i, bus_dat_i}), .q(line_s)
  );
  assign clk_s = line_s[1];
  assign dat_s = line_s[0];

  ps2rx_state_e      state, state_n;
  logic [CELL_W-1:0] cnt, cnt_n;
  logic [POLL_W-1:0] poll, poll_n;
  logic [ABT_W-1:0]  abt, abt_n;
  logic [IDX_W-1:0]  idx, idx_n;
  logic              ferr, ferr_n, samp, samp_n;
  logic              sh_en, sh_clr, v_n, a_n, r_n;
  logic [DATA_W-1:0] sh_data;
  logic              sh_odd;

  ps2rx_shift #(.DW(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .clr(sh_clr), .en(sh_en), .bit_i(dat_s),
    .data_o(sh_data), .odd_o(sh_odd)
  );

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    poll_n  = '0;
    abt_n   = '0;
    idx_n   = idx;
    ferr_n  = ferr;
    samp_n  = samp;
    sh_en   = 1'b0;
    sh_clr  = 1'b0;
    v_n     = 1'b0;
    a_n     = 1'b0;
    r_n     = 1'b0;
    case (state)
      ST_IDLE: begin
        poll_n = (poll == POLL_END) ? '0 : poll + 1'b1;
        if (poll == POLL_END && tx_idle && clk_s && !dat_s) begin
          state_n = ST_LOW;
          cnt_n   = '0;
          idx_n   = '0;
          ferr_n  = 1'b0;
          sh_clr  = 1'b1;
        end
      end
      ST_LOW, ST_ACK_LOW: begin
        if (cnt == HALF_END) begin
          state_n = (state == ST_LOW) ? ST_HIGH : ST_ACK_HIGH;
          cnt_n   = '0;
        end else cnt_n = cnt + 1'b1;
      end
      ST_HIGH: begin
        if (cnt >= GUARD && !clk_s) begin
          abt_n = abt + 1'b1;
          if (abt == ABT_END) begin
            state_n = ST_IDLE;
            a_n     = 1'b1;
          end
        end else if (cnt == HALF_END) begin
          cnt_n = '0;
          if (ferr) begin
            if (samp) begin
              state_n = ST_IDLE;
              r_n     = 1'b1;
            end else state_n = ST_LOW;
          end else if (idx == STOP_IDX) begin
            state_n = samp ? ST_ACK_LEAD : ST_LOW;
            ferr_n  = !samp;
          end else begin
            idx_n   = idx + 1'b1;
            state_n = ST_LOW;
          end
        end else begin
          cnt_n = cnt + 1'b1;
          if (cnt == SAMPLE_AT) begin
            samp_n = dat_s;
            sh_en  = !ferr && (idx <= PAR_IDX);
          end
        end
      end
      ST_ACK_LEAD: begin
        if (cnt == LEAD_END) begin
          state_n = ST_ACK_LOW;
          cnt_n   = '0;
        end else cnt_n = cnt + 1'b1;
      end
      ST_ACK_HIGH: begin
        if (cnt == HALF_END) begin
          state_n = ST_IDLE;
          v_n     = 1'b1;
        end else cnt_n = cnt + 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      cnt           <= '0;
      poll          <= '0;
      abt           <= '0;
      idx           <= '0;
      ferr          <= 1'b0;
      samp          <= 1'b0;
      clk_drive_low <= 1'b0;
      dat_drive_low <= 1'b0;
      busy          <= 1'b0;
      cmd_valid     <= 1'b0;
      cmd_byte      <= '0;
      cmd_par_err   <= 1'b0;
      host_abort    <= 1'b0;
      resend_req    <= 1'b0;
    end else begin
      state         <= state_n;
      cnt           <= cnt_n;
      poll          <= poll_n;
      abt           <= abt_n;
      idx           <= idx_n;
      ferr          <= ferr_n;
      samp          <= samp_n;
      clk_drive_low <= (state_n == ST_LOW) || (state_n == ST_ACK_LOW);
      dat_drive_low <= (state_n == ST_ACK_LEAD) || (state_n == ST_ACK_LOW) ||
                       (state_n == ST_ACK_HIGH);
      busy          <= (state_n != ST_IDLE);
      cmd_valid     <= v_n;
      host_abort    <= a_n;
      resend_req    <= r_n;
      if (v_n) begin
        cmd_byte    <= sh_data;
        cmd_par_err <= !sh_odd;
      end
    end
  end

  // Checker state: length of the current driven-low clock run.
  logic [CELL_W-1:0] lo_run;
  always_ff @(posedge clk) begin
    if (rst)                lo_run <= '0;
    else if (clk_drive_low) lo_run <= lo_run + 1'b1;
    else                    lo_run <= '0;
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!clk_drive_low && !dat_drive_low));  // R1
  AST_START_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(tx_idle));  // R2
  AST_LOW_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_drive_low) |-> (lo_run == CELL_W'(HALF_CYC)));  // R3
  AST_ACK_LEADS_EDGE: assert property (@(posedge clk) disable iff (rst)
    ($rose(clk_drive_low) && dat_drive_low) |-> $past(dat_drive_low));  // R6
  AST_ACK_ENDS_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $fell(dat_drive_low));  // R6
  AST_ABORT_FREES_BUS: assert property (@(posedge clk) disable iff (rst)
    host_abort |-> (!clk_drive_low && !dat_drive_low && !busy));  // R8
  AST_RESEND_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    resend_req |-> (!dat_drive_low && !busy));  // R7
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
    $countones({cmd_valid, host_abort, resend_req}) <= 1);  // R10
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);  // R10
endmodule

// File: tb/ps2_host_cmd_rx_tb.sv
module ps2_host_cmd_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_CYC   = 40;
  localparam int POLL_CYC   = 2000;
  localparam int ABORT_CYC  = 100;
  localparam int LEAD_CYC   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_idle = 1'b1;
  logic host_clk_low = 1'b0, host_dat_low = 1'b0;
  logic clk_drive_low, dat_drive_low, busy, cmd_valid, cmd_par_err, host_abort, resend_req;
  logic [7:0] cmd_byte;
  logic bus_clk, bus_dat;

  assign bus_clk = !(clk_drive_low || host_clk_low);
  assign bus_dat = !(dat_drive_low || host_dat_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_host_cmd_rx #(.DATA_W(8), .HALF_CYC(HALF_CYC), .POLL_CYC(POLL_CYC),
    .ABORT_CYC(ABORT_CYC), .LEAD_CYC(LEAD_CYC), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .bus_clk_i(bus_clk), .bus_dat_i(bus_dat), .tx_idle(tx_idle),
    .clk_drive_low(clk_drive_low), .dat_drive_low(dat_drive_low), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_par_err(cmd_par_err),
    .host_abort(host_abort), .resend_req(resend_req)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // Port monitor, sampled on the falling system edge.
  int n_clk, n_valid, n_abort, n_resend, n_multi, lo_bad, lc_gap;
  int cyc = 0, dat_rise_cyc = 0, lo_run = 0;
  logic [7:0] got_byte;
  logic got_perr;
  logic p_cl = 1'b0, p_dl = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (clk_drive_low && !p_cl) begin
        n_clk++;
        if (dat_drive_low) lc_gap = cyc - dat_rise_cyc;
      end
      if (dat_drive_low && !p_dl) dat_rise_cyc = cyc;
      if (clk_drive_low) lo_run++;
      else begin
        if (p_cl && lo_run != HALF_CYC) lo_bad++;
        lo_run = 0;
      end
      if (cmd_valid) begin n_valid++; got_byte = cmd_byte; got_perr = cmd_par_err; end
      if (host_abort) n_abort++;
      if (resend_req) n_resend++;
      if ((cmd_valid + host_abort + resend_req) > 1) n_multi++;
    end
    p_cl = clk_drive_low;
    p_dl = dat_drive_low;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_clk = 0; n_valid = 0; n_abort = 0; n_resend = 0; n_multi = 0; lc_gap = -1;
  endtask

  task automatic wait_rise();
    for (int g = 0; g < 20000; g++) begin
      @(negedge clk);
      if (clk_drive_low && !p_cl) return;
    end
  endtask

  task automatic wait_fall();
    for (int g = 0; g < 20000; g++) begin
      @(negedge clk);
      if (!clk_drive_low && p_cl) return;
    end
  endtask

  task automatic host_rts();
    host_clk_low = 1'b1;
    repeat (110) @(negedge clk);
    host_dat_low = 1'b1;
    repeat (5) @(negedge clk);
    host_clk_low = 1'b0;
  endtask

  // Drives 10 bits; optional clock hold in the released phase after bit hold_bit.
  // Returns early (abort) when the hold reaches ABORT_CYC.
  task automatic host_bits(input logic [7:0] b, input bit par_bad, input bit stop_bad,
                           input int extra, input int hold_bit, input int hold_len);
    logic [9:0] bits;
    bits = {!stop_bad, (~^b) ^ par_bad, b};
    for (int k = 0; k < 10; k++) begin
      wait_rise();
      repeat (3) @(negedge clk);
      host_dat_low = !bits[k];
      if (k == hold_bit) begin
        wait_fall();
        repeat (6) @(negedge clk);
        host_clk_low = 1'b1;
        repeat (hold_len) @(negedge clk);
        host_clk_low = 1'b0;
        if (hold_len >= ABORT_CYC) begin host_dat_low = 1'b0; return; end
      end
    end
    if (stop_bad) begin
      for (int e = 1; e <= extra; e++) begin
        wait_rise();
        repeat (3) @(negedge clk);
        if (e == extra) host_dat_low = 1'b0;
      end
    end
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 20000 && busy; g++) @(negedge clk);
    repeat (4) @(negedge clk);
    host_dat_low = 1'b0;
  endtask

  task automatic good_frame(input string tag, input logic [7:0] b, input bit par_bad,
                            input int hold_bit, input int hold_len);
    clear_mon();
    host_rts();
    host_bits(b, par_bad, 1'b0, 0, hold_bit, hold_len);
    wait_idle();
    check({tag, " R4 valid count"}, n_valid, 1);
    check({tag, " R4 byte"}, got_byte, b);
    check({tag, " R5 parity flag"}, got_perr, par_bad);
    check({tag, " R6 clock count"}, n_clk, 11);
    check({tag, " R6 ack lead"}, lc_gap, LEAD_CYC);
    check({tag, " R10 no abort/resend"}, n_abort + n_resend + n_multi, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_mon();
    lo_bad = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 clk_drive_low", clk_drive_low, 0);
    check("R1 dat_drive_low", dat_drive_low, 0);
    check("R1 busy", busy, 0);
    check("R1 strobes", cmd_valid + host_abort + resend_req, 0);

    good_frame("directed A5", 8'hA5, 1'b0, -1, 0);
    good_frame("directed 00 badpar", 8'h00, 1'b1, -1, 0);
    good_frame("directed FF", 8'hFF, 1'b0, -1, 0);

    // R7 framing error: stop low, released after 3 extra pulses
    clear_mon();
    host_rts();
    host_bits(8'h3C, 1'b0, 1'b1, 3, -1, 0);
    wait_idle();
    check("R7 resend count", n_resend, 1);
    check("R7 no valid", n_valid, 0);
    check("R7 clock count", n_clk, 13);
    check("R7 never drove data", lc_gap, -1);

    // R8 abort during bit 4
    clear_mon();
    host_rts();
    host_bits(8'h5A, 1'b0, 1'b0, 0, 3, ABORT_CYC + 30);
    @(negedge clk);
    check("R8 abort count", n_abort, 1);
    check("R8 no valid", n_valid, 0);
    check("R8 busy low", busy, 0);
    check("R8 clock released", clk_drive_low, 0);
    repeat (3 * POLL_CYC) @(negedge clk);
    check("R8 no restart", n_clk, 4);

    // R9 short hold stretches the cell
    good_frame("R9 stretch", 8'h96, 1'b0, 5, ABORT_CYC / 2);

    // R2 no start while the transmitter owns the bus
    clear_mon();
    tx_idle = 1'b0;
    host_rts();
    repeat (2 * POLL_CYC + 50) @(negedge clk);
    check("R2 busy while not granted", busy, 0);
    check("R2 no clock while not granted", n_clk, 0);
    tx_idle = 1'b1;
    host_bits(8'h81, 1'b0, 1'b0, 0, -1, 0);
    wait_idle();
    check("R2 byte after grant", got_byte, 8'h81);
    check("R2 valid after grant", n_valid, 1);

    for (int i = 0; i < 8; i++) begin
      logic [7:0] rb;
      bit pb;
      rb = 8'($urandom);
      pb = ($urandom % 4) == 0;
      good_frame("random", rb, pb, -1, 0);
    end

    check("R3 low pulse length", lo_bad, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule